// File: doc/BRIEF.md
# Masked Neighbour Bit-Manipulation Unit

This block performs one configurable bit-manipulation operation per clock. Each operation pairs an operand with an arithmetic neighbour of itself. From operand A it forms two words:

- A "primary" word, which is either A or its bitwise complement.
- A "neighbour" word, which is one of four increment or decrement forms of A.

A selectable logic operation merges the two words. The merged word is then limited to a mask taken from operand B. As an option, the bits outside the mask are refilled from A.

With a single control field the unit covers the usual lowest-set-bit idioms:

- isolate the lowest set bit;
- clear the lowest set bit;
- build a mask up to the lowest set bit;
- set the trailing zeros;
- the same tricks on clear bits.

An indicator marks the case where no B operand is present. In that case the mask spans the whole word. The result is registered, so it appears one clock after its inputs.

Top module: `masked_bitop_unit`

## Requirements
- R1: When `b_zero_i` is 1 the mask is all ones across XLEN bits and `b_i` has no effect. When it is 0 the mask equals `b_i`.
- R2: `ctrl_i[4]` selects the primary word: 0 gives the bitwise complement of A, 1 gives A unchanged.
- R3: `ctrl_i[1:0]` selects the neighbour word: 0 gives 0 minus A (two's-complement negation), 1 gives A minus 1, 2 gives A plus 1, 3 gives the complement of (A plus 1).
- R4: `ctrl_i[3:2]` selects how the primary and neighbour words are merged: 0 is OR, 1 is AND, 2 is XOR, and 3 (reserved) yields all zeros before masking.
- R5: With `restore_i` at 0, every result bit where the mask is 0 reads 0. Every other bit equals the merged word.
- R6: With `restore_i` at 1, every result bit where the mask is 0 equals the matching bit of A. Bits inside the mask are unchanged from R5.
- R7: All increments, decrements and negations wrap modulo 2^XLEN. A plus 1 of all ones is 0, and 0 minus 1 is all ones.
- R8: `result_o` is registered. It shows the operation sampled at a rising clock edge right after that edge, and it reads 0 while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | XLEN | Operand A |
| b_i | input | XLEN | Operand B, used as the mask |
| b_zero_i | input | 1 | B absent: use an all-ones mask |
| ctrl_i | input | 5 | Primary select [4], merge mode [3:2], neighbour mode [1:0] |
| restore_i | input | 1 | Refill bits outside the mask from A |
| result_o | output | XLEN | Registered result |

## Verification
Masking and restoration act on the same bits in the same cycle. Whenever `restore_i` is set with a sparse mask, the bits outside the mask must come from A while the bits inside it still come from the merge. Random operands are swept across all 32 control values with both restore settings, and every output is compared bit for bit against a bench model. Directed cases cover the other coincidences: the wrap corners, where the neighbour word crosses all ones or zero, and the reserved merge mode combined with restore.

// File: rtl/mbu_pkg.sv
package mbu_pkg;
  localparam int unsigned CTRL_W = 5;

  typedef enum logic [1:0] {
    NB_NEG  = 2'd0,
    NB_DEC  = 2'd1,
    NB_INC  = 2'd2,
    NB_NINC = 2'd3
  } nb_mode_e;

  typedef enum logic [1:0] {
    CMB_OR   = 2'd0,
    CMB_AND  = 2'd1,
    CMB_XOR  = 2'd2,
    CMB_RSVD = 2'd3
  } cmb_mode_e;

  typedef struct packed {
    logic      keep_a;
    cmb_mode_e cmb;
    nb_mode_e  nb;
  } ctrl_t;
endpackage

// File: rtl/mbu_mask_gen.sv
module mbu_mask_gen #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] b_i,
  input  logic            b_zero_i,
  output logic [XLEN-1:0] mask_o
);
  assign mask_o = b_zero_i ? {XLEN{1'b1}} : b_i;
endmodule

// File: rtl/mbu_operand_gen.sv
module mbu_operand_gen
  import mbu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic            keep_a_i,
  input  nb_mode_e        nb_i,
  output logic [XLEN-1:0] prim_o,
  output logic [XLEN-1:0] nbr_o
);
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] a_inc;
  logic [XLEN-1:0] a_dec;

  assign a_inc  = a_i + ONE;
  assign a_dec  = a_i - ONE;
  assign prim_o = keep_a_i ? a_i : ~a_i;

  always_comb begin
    unique case (nb_i)
      NB_NEG:  nbr_o = ~a_dec;   // -a == ~(a-1)
      NB_DEC:  nbr_o = a_dec;
      NB_INC:  nbr_o = a_inc;
      default: nbr_o = ~a_inc;
    endcase
  end
endmodule

// File: rtl/mbu_combine.sv
module mbu_combine
  import mbu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] prim_i,
  input  logic [XLEN-1:0] nbr_i,
  input  cmb_mode_e       cmb_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic [XLEN-1:0] a_i,
  input  logic            restore_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] merged;
  logic [XLEN-1:0] masked;

  always_comb begin
    unique case (cmb_i)
      CMB_OR:  merged = prim_i | nbr_i;
      CMB_AND: merged = prim_i & nbr_i;
      CMB_XOR: merged = prim_i ^ nbr_i;
      default: merged = '0;
    endcase
  end

  assign masked = merged & mask_i;
  assign res_o  = restore_i ? (masked | (a_i & ~mask_i)) : masked;
endmodule

// File: rtl/masked_bitop_unit.sv
module masked_bitop_unit
  import mbu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [XLEN-1:0]     a_i,
  input  logic [XLEN-1:0]     b_i,
  input  logic                b_zero_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  input  logic                restore_i,
  output logic [XLEN-1:0]     result_o
);
  ctrl_t           ctrl;
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] prim;
  logic [XLEN-1:0] nbr;
  logic [XLEN-1:0] res_d;
  logic [XLEN-1:0] res_q;

  assign ctrl = ctrl_t'(ctrl_i);

  mbu_mask_gen #(.XLEN(XLEN)) mask_i (
    .b_i      (b_i),
    .b_zero_i (b_zero_i),
    .mask_o   (mask)
  );

  mbu_operand_gen #(.XLEN(XLEN)) opnd_i (
    .a_i      (a_i),
    .keep_a_i (ctrl.keep_a),
    .nb_i     (ctrl.nb),
    .prim_o   (prim),
    .nbr_o    (nbr)
  );

  mbu_combine #(.XLEN(XLEN)) comb_i (
    .prim_i    (prim),
    .nbr_i     (nbr),
    .cmb_i     (ctrl.cmb),
    .mask_i    (mask),
    .a_i       (a_i),
    .restore_i (restore_i),
    .res_o     (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign result_o = res_q;
endmodule

// File: rtl/masked_bitop_unit_chk.sv
module masked_bitop_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic            b_zero_i,
  input logic [4:0]      ctrl_i,
  input logic            restore_i,
  input logic [XLEN-1:0] result_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_MASK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(restore_i) && !$past(b_zero_i)) |-> ((result_o & ~$past(b_i)) == '0)); // R5

  AST_RESTORE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(restore_i) && !$past(b_zero_i)) |->
      ((result_o & ~$past(b_i)) == ($past(a_i) & ~$past(b_i)))); // R6

  AST_FULL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(b_zero_i) && ($past(ctrl_i[4:2]) == 3'b100)) |->
      ((result_o & $past(a_i)) == $past(a_i))); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ($past(ctrl_i[3:2]) == 2'b11) && !$past(restore_i)) |-> (result_o == '0)); // R4

  AST_KEEP_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ($past(ctrl_i[4:2]) == 3'b101) && !$past(restore_i)) |->
      ((result_o & ~$past(a_i)) == '0)); // R2
endmodule

bind masked_bitop_unit masked_bitop_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_i       (a_i),
  .b_i       (b_i),
  .b_zero_i  (b_zero_i),
  .ctrl_i    (ctrl_i),
  .restore_i (restore_i),
  .result_o  (result_o)
);

// File: tb/masked_bitop_unit_tb_top.sv
module masked_bitop_unit_tb_top;
  localparam int unsigned XLEN = 64;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [XLEN-1:0] a_i = '0;
  logic [XLEN-1:0] b_i = '0;
  logic            b_zero_i = 1'b0;
  logic [4:0]      ctrl_i = '0;
  logic            restore_i = 1'b0;
  logic [XLEN-1:0] result_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  masked_bitop_unit #(.XLEN(XLEN)) dut_i (.*);

  function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                            input logic bz, input logic [4:0] c, input logic rs);
    logic [XLEN-1:0] m, p, n, r;
    m = bz ? ONES : b;
    p = c[4] ? a : ~a;
    case (c[1:0])
      2'd0: n = 0 - a;
      2'd1: n = a - 1;
      2'd2: n = a + 1;
      default: n = ~(a + 1);
    endcase
    case (c[3:2])
      2'd0: r = p | n;
      2'd1: r = p & n;
      2'd2: r = p ^ n;
      default: r = '0;
    endcase
    r = r & m;
    if (rs) r = r | (a & ~m);
    return r;
  endfunction

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic run(input string tag, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                     input logic bz, input logic [4:0] c, input logic rs, input logic [XLEN-1:0] exp);
    @(negedge clk_i);
    a_i = a; b_i = b; b_zero_i = bz; ctrl_i = c; restore_i = rs;
    @(negedge clk_i);
    check(tag, result_o, exp);
  endtask

  task automatic run_m(input string tag, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic bz, input logic [4:0] c, input logic rs);
    run(tag, a, b, bz, c, rs, model(a, b, bz, c, rs));
  endtask

  initial begin
    logic [XLEN-1:0] ra, rb;
    void'($urandom(32'd1234));
    a_i = 64'hFFFF_0000_1234_5678;
    #(CLK_PERIOD*2);
    check("R8 reset", result_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3/R4: isolate lowest set bit, A & -A
    run("R3 isolate lsb", 64'h58, '0, 1'b1, 5'b10100, 1'b0, 64'h8);
    // clear lowest set bit, A & (A-1)
    run("R3 clear lsb", 64'h58, '0, 1'b1, 5'b10101, 1'b0, 64'h50);
    // mask up to lowest set bit, A ^ (A-1)
    run("R4 xor mask", 64'h58, '0, 1'b1, 5'b11001, 1'b0, 64'hF);
    // R2: ~A & (A+1) isolates lowest clear bit
    run("R2 lowest clear", 64'h57, '0, 1'b1, 5'b00110, 1'b0, 64'h8);
    // R7: wrap corners
    run("R7 inc wrap", ONES, '0, 1'b1, 5'b10110, 1'b0, '0);
    run("R7 dec wrap", '0, '0, 1'b1, 5'b00101, 1'b0, ONES);
    run("R7 neg zero", '0, '0, 1'b1, 5'b11000, 1'b0, '0);
    // R1: b ignored when b_zero set
    run("R1 b ignored", 64'h58, 64'h0000_0000_0000_00F0, 1'b1, 5'b10100, 1'b0, 64'h8);
    run("R1 mask is b", 64'h58, 64'h0000_0000_0000_00F0, 1'b0, 5'b10100, 1'b0, 64'h0);
    // R5/R6 sparse mask
    run("R5 masked", 64'hFF, 64'h0F, 1'b0, 5'b10000, 1'b0, 64'h0F);
    run("R6 restore", 64'hA5A5, 64'h000F, 1'b0, 5'b11100, 1'b1, 64'hA5A0);
    run("R4 reserved", 64'h1234, ONES, 1'b0, 5'b01100, 1'b0, '0);

    for (int i = 0; i < 400; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 7 == 0) ra = ra & 64'hFFFF_FF00;
      run_m("R3/R4/R5/R6 random", ra, rb, ($urandom % 4) == 0, 5'(i % 32), 1'(($urandom) & 1));
    end
    for (int c = 0; c < 32; c++)
      run_m("R2/R3/R4 sweep", 64'h8000_0000_0000_0000, 64'hF0F0_F0F0_F0F0_F0F0, 1'b0, 5'(c), 1'(c & 1));

    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R8 async reset", result_o, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule